// File: doc/BRIEF.md
# Dual-Channel Correlating Tone Analyzer

This block measures how a device under test responds at one test frequency. Each digitized response sample is multiplied by two reference sinusoids of that frequency, a quarter cycle apart. Each product is summed into its own signed accumulator. The two sums together give the in-phase and quadrature parts of the response's spectral component at that frequency. Later logic derives magnitude and phase delay from them, and that logic is not part of this block.

A test controller loads a 24-bit tuning word, a starting phase and a sample count, then pulses `start`. The block then takes the requested number of samples, counting only cycles in which `sample_en` is high. It raises `done` for one cycle when the last product has been added. To sweep a band, the controller loads a new tuning word and starts again for each frequency point. The references come from an internal phase accumulator that addresses a quarter-wave sine table.

Top module: `tone_correlator`

## Requirements
- R1: After reset, `acc_sin` and `acc_cos` are zero, and `done` and `busy` are low.
- R2: A `start` pulse clears both accumulators, loads `phase_ofs` into the phase accumulator, and captures `tune_word` and `len_m1`. `busy` is high from the next cycle. A sample offered in the same cycle as `start` is not used. A `start` during a measurement abandons that measurement and begins a new one.
- R3: The reference is set by phase bits [23:14], a 10-bit address. Address bits [9:8] give the quadrant q and bits [7:0] give the index i. The table entry is T[k] = round(2047·sin(π/2·(k+0.5)/256)). The magnitude is T[i] for q = 0 or 2 and T[255−i] for q = 1 or 3. It is negated for q = 2 or 3. The sine reference uses the phase itself. The cosine reference uses the phase plus 2^22, modulo 2^24.
- R4: The phase advances by the captured tuning word after each enabled sample only, and wraps modulo 2^24.
- R5: `acc_sin` holds the sum of sample × sine reference, and `acc_cos` holds the sum of sample × cosine reference. The sums cover exactly `len_m1`+1 enabled samples. Cycles with `sample_en` low contribute nothing and do not advance the phase.
- R6: Each accumulation saturates at the largest or smallest signed value of the accumulator width instead of wrapping. Later products of the opposite sign move the sum away from the limit again.
- R7: Let E be the clock edge that captures the last enabled sample. `done` is high for exactly one cycle, after edge E+1. `busy` falls in that same cycle. The accumulators then hold their values, and enabled samples are ignored until the next `start`.
- R8: Back-to-back measurements with different tuning words each produce results for their own frequency, with no carry-over from the previous measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement (one-cycle pulse) |
| sample_en | input | 1 | Marks a valid response sample |
| sample_in | input | 12 | Signed response sample |
| tune_word | input | 24 | Phase step per sample |
| phase_ofs | input | 24 | Initial reference phase |
| len_m1 | input | 16 | Number of samples minus one |
| acc_sin | output | ACC_W | Signed sum against the sine reference |
| acc_cos | output | ACC_W | Signed sum against the cosine reference |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with a 28-bit accumulator and keeps every other parameter at its default. With the default 40-bit accumulator, the largest possible sum of 65536 full-scale products cannot reach the limit. With 28 bits, about forty full-scale products drive it into positive or negative saturation, so the clamping and the recovery from the limit are reached within short directed runs. The sample, phase, table and count widths stay at their defaults. The quadrant mapping, the phase wrap and the length encoding are therefore exercised at their true sizes.

// File: rtl/tone_correlator.sv
module tone_correlator #(
  parameter int SMP_W  = 12,
  parameter int PH_W   = 24,
  parameter int LUT_AW = 8,
  parameter int REF_W  = 12,
  parameter int ACC_W  = 40,
  parameter int LEN_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    sample_en,
  input  logic signed [SMP_W-1:0] sample_in,
  input  logic [PH_W-1:0]         tune_word,
  input  logic [PH_W-1:0]         phase_ofs,
  input  logic [LEN_W-1:0]        len_m1,
  output logic signed [ACC_W-1:0] acc_sin,
  output logic signed [ACC_W-1:0] acc_cos,
  output logic                    busy,
  output logic                    done
);

  localparam int PROD_W  = SMP_W + REF_W;
  localparam int ADDR_W  = LUT_AW + 2;
  localparam int ENTRIES = 1 << LUT_AW;
  localparam int AMP     = (1 << (REF_W - 1)) - 1;
  localparam logic [PH_W-1:0] QTR = PH_W'(1) << (PH_W - 2);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic int qsin(int k);
    real x;
    x = real'(AMP) * $sin(3.14159265358979 * (real'(k) + 0.5) / (2.0 * real'(ENTRIES)));
    return $rtoi(x + 0.5);
  endfunction

  logic [REF_W-2:0] lut [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_lut
    localparam int V = qsin(i);
    assign lut[i] = (REF_W-1)'(V);
  end

  logic [PH_W-1:0]  phase, tune_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic             run, pvld, last_p, busy_q, done_q;

  wire take = run && sample_en && !start;
  wire last = (cnt == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      tune_q <= '0;
      len_q  <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      pvld   <= 1'b0;
      last_p <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pvld   <= 1'b0;
      last_p <= 1'b0;
      if (start) begin
        phase  <= phase_ofs;
        tune_q <= tune_word;
        len_q  <= len_m1;
        cnt    <= '0;
        run    <= 1'b1;
        busy_q <= 1'b1;
      end else begin
        if (take) begin
          phase  <= phase + tune_q;
          cnt    <= cnt + 1'b1;
          pvld   <= 1'b1;
          last_p <= last;
          if (last) run <= 1'b0;
        end
        if (pvld && last_p) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  logic signed [ACC_W-1:0] acc [2];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire [PH_W-1:0]   ph   = (c == 0) ? phase : phase + QTR;
    wire [ADDR_W-1:0] addr = ph[PH_W-1 -: ADDR_W];
    wire [1:0]        quad = addr[ADDR_W-1 -: 2];
    wire [LUT_AW-1:0] idx  = quad[0] ? ~addr[LUT_AW-1:0] : addr[LUT_AW-1:0];
    wire signed [REF_W-1:0] mag  = $signed({1'b0, lut[idx]});
    wire signed [REF_W-1:0] refv = quad[1] ? -mag : mag;

    logic signed [PROD_W-1:0] prod;
    wire signed [ACC_W:0] sum = {acc[c][ACC_W-1], acc[c]} + (ACC_W+1)'(prod);
    wire ovf = sum[ACC_W] != sum[ACC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else if (take) prod <= PROD_W'(sample_in) * PROD_W'(refv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc[c] <= '0;
      else if (start) acc[c] <= '0;
      else if (pvld)  acc[c] <= ovf ? (sum[ACC_W] ? ACC_MIN : ACC_MAX) : sum[ACC_W-1:0];
    end
  end

  assign acc_sin = acc[0];
  assign acc_cos = acc[1];
  assign busy    = busy_q;
  assign done    = done_q;

endmodule

// File: rtl/tone_correlator_chk.sv
module tone_correlator_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [ACC_W-1:0] acc_sin,
  input logic [ACC_W-1:0] acc_cos,
  input logic             busy,
  input logic             done
);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_sin == '0 && acc_cos == '0 && busy));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(acc_sin) && $stable(acc_cos)));

endmodule

bind tone_correlator tone_correlator_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .acc_sin(acc_sin), .acc_cos(acc_cos), .busy(busy), .done(done)
);

// File: tb/sim_tone_correlator.sv
module sim_tone_correlator;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 28;
  localparam longint SMAX = (64'sd1 <<< (AW-1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (AW-1));

  logic clk = 0, rst_n = 0, start = 0, sample_en = 0;
  logic signed [11:0] sample_in = '0;
  logic [23:0] tune_word = '0, phase_ofs = '0;
  logic [15:0] len_m1 = '0;
  logic signed [AW-1:0] acc_sin, acc_cos;
  logic busy, done;

  int n_chk = 0, n_bad = 0;
  int tab [256];
  logic [23:0] m_ph, m_tw;
  longint m_s, m_c;

  tone_correlator #(.ACC_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_en(sample_en),
    .sample_in(sample_in), .tune_word(tune_word), .phase_ofs(phase_ofs),
    .len_m1(len_m1), .acc_sin(acc_sin), .acc_cos(acc_cos), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(longint act, longint exp, string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mref(logic [23:0] ph);
    logic [9:0] a = ph[23:14];
    int m = a[8] ? tab[255 - int'(a[7:0])] : tab[int'(a[7:0])];
    return a[9] ? -m : m;
  endfunction

  function automatic longint sat(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic begin_meas(logic [23:0] tw, logic [23:0] po, int len);
    start = 1; tune_word = tw; phase_ofs = po; len_m1 = 16'(len - 1);
    sample_en = 1; sample_in = 12'sh7FF;
    @(negedge clk);
    start = 0; sample_en = 0;
    m_ph = po; m_tw = tw; m_s = 0; m_c = 0;
    check(longint'(busy), 1, "R2 busy after start");
    check(longint'(acc_sin), 0, "R2 sin cleared");
    check(longint'(acc_cos), 0, "R2 cos cleared");
  endtask

  task automatic push(int smp, bit en);
    sample_in = 12'(smp); sample_en = en;
    if (en) begin
      m_s = sat(m_s + longint'(smp) * mref(m_ph));
      m_c = sat(m_c + longint'(smp) * mref(m_ph + 24'h400000));
      m_ph = m_ph + m_tw;
    end
    @(negedge clk);
    sample_en = 0;
  endtask

  task automatic finish_meas(string req);
    check(longint'(done), 0, "R7 done not early");
    push(0, 0);
    check(longint'(done), 1, "R7 done timing");
    check(longint'(busy), 0, "R7 busy low at done");
    check(longint'(acc_sin), m_s, {req, " sin sum"});
    check(longint'(acc_cos), m_c, {req, " cos sum"});
    push(0, 0);
    check(longint'(done), 0, "R7 done one cycle");
  endtask

  task automatic t_tone(logic [23:0] tw, logic [23:0] po, int len, int gap, int seed, string req);
    begin_meas(tw, po, len);
    for (int i = 0; i < len; i++) begin
      if (gap != 0 && i % gap == 1) push(1234, 0);
      push(((i * 1103 + seed * 37) % 4096) - 2048, 1);
    end
    finish_meas(req);
  endtask

  task automatic t_ref_points;
    int exp_s [4] = '{6, 2047, -6, -2047};
    int exp_c [4] = '{2047, -6, -2047, 6};
    logic [23:0] pos [4] = '{24'h000000, 24'h400000, 24'h800000, 24'hC00000};
    for (int q = 0; q < 4; q++) begin
      begin_meas(0, pos[q], 1);
      push(1, 1);
      push(0, 0);
      check(longint'(acc_sin), exp_s[q], "R3 sine quadrant");
      check(longint'(acc_cos), exp_c[q], "R3 cosine quadrant");
    end
    begin_meas(0, 24'h3FC000, 1);
    push(1, 1);
    push(0, 0);
    check(longint'(acc_sin), 2047, "R3 table peak");
    check(longint'(acc_cos), 6, "R3 table low end");
  endtask

  task automatic t_sat;
    begin_meas(0, 24'h3FC000, 40);
    for (int i = 0; i < 40; i++) push(2047, 1);
    finish_meas("R6 positive");
    check(longint'(acc_sin), SMAX, "R6 clamp max");
    begin_meas(0, 24'h3FC000, 40);
    for (int i = 0; i < 40; i++) push(-2048, 1);
    finish_meas("R6 negative");
    check(longint'(acc_sin), SMIN, "R6 clamp min");
    begin_meas(0, 24'h3FC000, 45);
    for (int i = 0; i < 40; i++) push(2047, 1);
    for (int i = 0; i < 5; i++) push(-2048, 1);
    finish_meas("R6 recovery");
  endtask

  task automatic t_restart;
    begin_meas(24'h123456, 24'h010000, 10);
    for (int i = 0; i < 5; i++) push(900 - i * 50, 1);
    begin_meas(24'h0A0000, 24'h200000, 4);
    for (int i = 0; i < 4; i++) push(-700 + i * 300, 1);
    finish_meas("R2 restart");
  endtask

  task automatic t_hold;
    logic signed [AW-1:0] hs, hc;
    t_tone(24'h031000, 24'h000000, 6, 0, 3, "R5 before hold");
    hs = acc_sin; hc = acc_cos;
    for (int i = 0; i < 5; i++) begin
      sample_in = 12'sh5A5; sample_en = 1;
      @(negedge clk);
    end
    sample_en = 0;
    check(longint'(acc_sin), longint'(hs), "R7 sin held");
    check(longint'(acc_cos), longint'(hc), "R7 cos held");
    check(longint'(done), 0, "R7 no done while idle");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++)
      tab[k] = $rtoi(2047.0 * $sin(3.14159265358979 * (real'(k) + 0.5) / 512.0) + 0.5);
    @(negedge clk);
    check(longint'(acc_sin), 0, "R1 sin reset");
    check(longint'(acc_cos), 0, "R1 cos reset");
    check(longint'(busy), 0, "R1 busy reset");
    check(longint'(done), 0, "R1 done reset");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_ref_points();
    t_tone(24'h040000, 24'h000000, 64, 0, 1, "R5 contiguous");
    t_tone(24'h0C3500, 24'h123456, 50, 3, 2, "R5 with gaps");
    t_tone(24'hFF0000, 24'hF00000, 30, 2, 4, "R4 wrap");
    t_tone(24'h000000, 24'h000000, 1, 0, 5, "R5 single sample");
    t_sat();
    t_restart();
    t_hold();
    t_tone(24'h020000, 24'h000000, 40, 0, 6, "R8 sweep point A");
    t_tone(24'h055555, 24'h000000, 40, 0, 6, "R8 sweep point B");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule